// File: doc/BRIEF.md
# EEPROM Page Write Buffer

This block sits between a serial-bus slave front end and the storage array of a byte-addressed nonvolatile memory. The front end hands it a starting address, then a stream of data-byte strobes, and finally a commit pulse when the bus transaction ends. Bytes are not written to the array as they arrive. They are collected in a page-sized buffer, each with its own valid flag. The commit pulse then starts a timed write cycle, during which only the loaded byte slots are copied into the addressed page.

The block also owns the shared byte address counter. While bytes are loaded, only the in-page offset advances, so a long burst wraps around inside one page and later bytes replace earlier ones. Read requests advance the full address, crossing page boundaries and wrapping from the top of the array back to zero. While the write cycle runs, the block reports busy and ignores every request. The array is a single-port synchronous RAM that starts with every byte at FFh. Its depth is set by `ADDR_W`: 11 gives 2,048 bytes, and 14 gives 16,384 bytes arranged as 256 pages of 64.

Top module: `eeprom_page_buf`

## Requirements
- R1: After reset, addr_o is 0, busy_o is 0 and rd_vld_o is 0.
- R2: Every array byte reads FFh until a commit writes it.
- R3: An addr_load_i accepted while idle sets addr_o to addr_i on the next cycle and discards every byte loaded but not yet committed.
- R4: An accepted byte_vld_i stores byte_i at in-page offset addr_o[PAGE_W-1:0]. It then raises that offset by one modulo 2^PAGE_W and leaves the page bits addr_o[ADDR_W-1:PAGE_W] unchanged. A later byte at the same offset replaces the earlier one.
- R5: The array is not changed before a commit. A commit writes the loaded bytes into page addr_o[ADDR_W-1:PAGE_W], and the other bytes of that page keep their contents.
- R6: An accepted commit_i with at least one loaded byte raises busy_o on the next cycle. busy_o then stays high for exactly WR_CYCLES cycles, or 2^PAGE_W cycles if that is larger.
- R7: A commit_i with no loaded bytes leaves busy_o low and the array unchanged.
- R8: While busy_o is high, addr_load_i, byte_vld_i, rd_req_i and commit_i are ignored: addr_o holds, rd_vld_o stays low, and no byte is buffered.
- R9: An accepted rd_req_i gives rd_vld_o=1 and rd_data_o equal to the array byte at addr_o on the next cycle. addr_o then advances by one modulo 2^ADDR_W, crossing pages and wrapping from the last address to 0.
- R10: Requests in the same idle cycle are served with addr_load_i first, then byte_vld_i, then rd_req_i. A lower request is dropped, and a byte that arrives together with commit_i is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| addr_load_i | input | 1 | Load addr_i into the address counter |
| addr_i | input | ADDR_W | Start address of a transaction |
| byte_vld_i | input | 1 | Strobe: byte_i is a write data byte |
| byte_i | input | 8 | Write data byte |
| commit_i | input | 1 | End of transaction: start the write cycle |
| rd_req_i | input | 1 | Read the byte at the current address |
| addr_o | output | ADDR_W | Current byte address counter |
| busy_o | output | 1 | Write cycle in progress |
| rd_vld_o | output | 1 | rd_data_o holds a read result |
| rd_data_o | output | 8 | Read data |

## Verification
Address updates from loads, bytes and reads appear on addr_o one cycle after the request. Read data and rd_vld_o also arrive one cycle after rd_req_i, and busy_o rises one cycle after the commit and stays high for exactly the write-cycle length. The bench drives every request on a falling edge and samples the outputs on the next falling edge, one rising edge later. For the busy window it counts the falling edges at which busy_o is high. Expected array contents, pending buffer slots and address values come from a bench model built from the requirements. Directed cases cover page wrap, partial-page merge, discard on reload, empty commit, pokes during busy, and top-of-array read wrap. Seeded random bursts follow them.

// File: rtl/eeprom_pb_pkg.sv
package eeprom_pb_pkg;
  localparam int DATA_W = 8;

  typedef enum logic [1:0] {
    ADDR_HOLD,
    ADDR_LOAD,
    ADDR_STEP_PAGE,
    ADDR_STEP_FULL
  } addr_op_e;
endpackage

// File: rtl/pb_addr_ctr.sv
module pb_addr_ctr
  import eeprom_pb_pkg::*;
#(
  parameter int ADDR_W = 11,
  parameter int PAGE_W = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  addr_op_e          op_i,
  input  logic [ADDR_W-1:0] load_val_i,
  output logic [ADDR_W-1:0] addr_o
);
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [PAGE_W-1:0] off_inc;

  assign off_inc = addr_q[PAGE_W-1:0] + PAGE_W'(1);

  always_comb begin
    addr_d = addr_q;
    unique case (op_i)
      ADDR_LOAD:      addr_d = load_val_i;
      // write side: offset wraps inside the page
      ADDR_STEP_PAGE: addr_d = {addr_q[ADDR_W-1:PAGE_W], off_inc};
      // read side: wraps at end of array
      ADDR_STEP_FULL: addr_d = addr_q + ADDR_W'(1);
      default:        addr_d = addr_q;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) addr_q <= '0;
    else         addr_q <= addr_d;
  end

  assign addr_o = addr_q;
endmodule

// File: rtl/pb_page_buf.sv
module pb_page_buf
  import eeprom_pb_pkg::*;
#(
  parameter int PAGE_W = 6,
  localparam int PAGE_BYTES = 1 << PAGE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_i,
  input  logic              wr_i,
  input  logic [PAGE_W-1:0] wr_off_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              drain_start_i,
  output logic              any_vld_o,
  output logic              drain_act_o,
  output logic              drain_we_o,
  output logic [PAGE_W-1:0] drain_off_o,
  output logic [DATA_W-1:0] drain_data_o
);
  logic [PAGE_BYTES-1:0] slot_vld;
  logic [DATA_W-1:0]     slot_data [PAGE_BYTES];
  logic                  drain_q;
  logic [PAGE_W-1:0]     doff_q;

  for (genvar g = 0; g < PAGE_BYTES; g++) begin : g_slot
    logic              v_q;
    logic [DATA_W-1:0] d_q;
    logic              hit_wr, hit_drain;

    assign hit_wr    = wr_i && (wr_off_i == PAGE_W'(g));
    assign hit_drain = drain_q && (doff_q == PAGE_W'(g));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        v_q <= 1'b0;
      else if (clear_i)   v_q <= 1'b0;
      else if (hit_wr)    v_q <= 1'b1;
      else if (hit_drain) v_q <= 1'b0;
    end

    always_ff @(posedge clk_i) begin
      if (hit_wr) d_q <= wr_data_i;
    end

    assign slot_vld[g]  = v_q;
    assign slot_data[g] = d_q;
  end

  // drain walks every slot once, one per cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      drain_q <= 1'b0;
      doff_q  <= '0;
    end else if (drain_start_i) begin
      drain_q <= 1'b1;
      doff_q  <= '0;
    end else if (drain_q) begin
      doff_q <= doff_q + PAGE_W'(1);
      if (&doff_q) drain_q <= 1'b0;
    end
  end

  assign any_vld_o    = |slot_vld;
  assign drain_act_o  = drain_q;
  assign drain_we_o   = drain_q && slot_vld[doff_q];
  assign drain_off_o  = doff_q;
  assign drain_data_o = slot_data[doff_q];
endmodule

// File: rtl/pb_wr_timer.sv
module pb_wr_timer #(
  parameter int CYCLES = 64,
  localparam int CW = $clog2(CYCLES + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic busy_o
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           cnt_q <= '0;
    else if (start_i)      cnt_q <= CW'(CYCLES);
    else if (cnt_q != '0)  cnt_q <= cnt_q - CW'(1);
  end

  assign busy_o = (cnt_q != '0);
endmodule

// File: rtl/pb_sp_ram.sv
module pb_sp_ram
  import eeprom_pb_pkg::*;
#(
  parameter int ADDR_W = 11,
  localparam int DEPTH = 1 << ADDR_W
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic              re_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] mem [DEPTH];

  // erased state
  initial begin
    for (int i = 0; i < DEPTH; i++) mem[i] = '1;
  end

  always_ff @(posedge clk_i) begin
    if (we_i) mem[addr_i] <= wdata_i;
    if (re_i) rdata_o <= mem[addr_i];
  end
endmodule

// File: rtl/eeprom_page_buf.sv
module eeprom_page_buf
  import eeprom_pb_pkg::*;
#(
  parameter int ADDR_W    = 11,
  parameter int PAGE_W    = 6,
  parameter int WR_CYCLES = 500000,
  localparam int PAGE_BYTES = 1 << PAGE_W,
  localparam int WR_LEN     = (WR_CYCLES > PAGE_BYTES) ? WR_CYCLES : PAGE_BYTES
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              addr_load_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              byte_vld_i,
  input  logic [DATA_W-1:0] byte_i,
  input  logic              commit_i,
  input  logic              rd_req_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              busy_o,
  output logic              rd_vld_o,
  output logic [DATA_W-1:0] rd_data_o
);
  logic              idle;
  logic              take_load, take_byte, take_rd, commit_ok;
  logic              buf_any, drain_act, drain_we;
  logic [PAGE_W-1:0] drain_off;
  logic [DATA_W-1:0] drain_data;
  logic [ADDR_W-1:0] cur_addr, ram_addr;
  logic              rd_vld_q;
  addr_op_e          addr_op;

  assign idle      = !busy_o;
  assign take_load = idle && addr_load_i;
  assign take_byte = idle && byte_vld_i && !addr_load_i && !commit_i;
  assign take_rd   = idle && rd_req_i && !addr_load_i && !byte_vld_i && !commit_i;
  assign commit_ok = idle && commit_i && !addr_load_i && buf_any;

  always_comb begin
    if (take_load)      addr_op = ADDR_LOAD;
    else if (take_byte) addr_op = ADDR_STEP_PAGE;
    else if (take_rd)   addr_op = ADDR_STEP_FULL;
    else                addr_op = ADDR_HOLD;
  end

  pb_addr_ctr #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_addr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .op_i       (addr_op),
    .load_val_i (addr_i),
    .addr_o     (cur_addr)
  );

  pb_page_buf #(.PAGE_W(PAGE_W)) u_buf (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .clear_i       (take_load),
    .wr_i          (take_byte),
    .wr_off_i      (cur_addr[PAGE_W-1:0]),
    .wr_data_i     (byte_i),
    .drain_start_i (commit_ok),
    .any_vld_o     (buf_any),
    .drain_act_o   (drain_act),
    .drain_we_o    (drain_we),
    .drain_off_o   (drain_off),
    .drain_data_o  (drain_data)
  );

  pb_wr_timer #(.CYCLES(WR_LEN)) u_timer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (commit_ok),
    .busy_o  (busy_o)
  );

  // page bits cannot move while busy, so the counter supplies the page
  assign ram_addr = drain_act ? {cur_addr[ADDR_W-1:PAGE_W], drain_off} : cur_addr;

  pb_sp_ram #(.ADDR_W(ADDR_W)) u_ram (
    .clk_i   (clk_i),
    .we_i    (drain_we),
    .re_i    (take_rd),
    .addr_i  (ram_addr),
    .wdata_i (drain_data),
    .rdata_o (rd_data_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rd_vld_q <= 1'b0;
    else         rd_vld_q <= take_rd;
  end

  assign rd_vld_o = rd_vld_q;
  assign addr_o   = cur_addr;
endmodule

// File: rtl/eeprom_page_buf_chk.sv
module eeprom_page_buf_chk #(
  parameter int ADDR_W = 11,
  parameter int PAGE_W = 6,
  parameter int WR_LEN = 64
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              addr_load_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic              byte_vld_i,
  input logic              commit_i,
  input logic              rd_req_i,
  input logic [ADDR_W-1:0] addr_o,
  input logic              busy_o,
  input logic              rd_vld_o,
  input logic              buf_any,
  input logic              drain_act
);
  int unsigned       busy_len;
  logic [PAGE_W-1:0] off_nx;
  logic [ADDR_W-1:0] addr_nx;
  logic              byte_ok, rd_ok;

  assign off_nx  = addr_o[PAGE_W-1:0] + PAGE_W'(1);
  assign addr_nx = addr_o + ADDR_W'(1);
  assign byte_ok = byte_vld_i && !busy_o && !addr_load_i && !commit_i;
  assign rd_ok   = rd_req_i && !busy_o && !addr_load_i && !byte_vld_i && !commit_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     busy_len <= 0;
    else if (busy_o) busy_len <= busy_len + 1;
    else             busy_len <= 0;
  end

  AST_LOAD_ADDR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    addr_load_i && !busy_o |=> addr_o == $past(addr_i)); // R3
  AST_PAGE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_ok |=> addr_o[ADDR_W-1:PAGE_W] == $past(addr_o[ADDR_W-1:PAGE_W]) &&
                addr_o[PAGE_W-1:0] == $past(off_nx)); // R4
  AST_DRAIN_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> !drain_act && !buf_any); // R5
  AST_BUSY_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(commit_i)); // R6
  AST_BUSY_LEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> busy_len == WR_LEN); // R6
  AST_EMPTY_COMMIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_i && !busy_o && !buf_any |=> !busy_o); // R7
  AST_BUSY_IGNORE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> $stable(addr_o) && !rd_vld_o); // R8
  AST_RD_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_ok |=> rd_vld_o && addr_o == $past(addr_nx)); // R9
  AST_RD_LOWPRIO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_req_i && (addr_load_i || byte_vld_i) |=> !rd_vld_o); // R10
endmodule

bind eeprom_page_buf eeprom_page_buf_chk #(
  .ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .WR_LEN(WR_LEN)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .addr_load_i (addr_load_i),
  .addr_i      (addr_i),
  .byte_vld_i  (byte_vld_i),
  .commit_i    (commit_i),
  .rd_req_i    (rd_req_i),
  .addr_o      (addr_o),
  .busy_o      (busy_o),
  .rd_vld_o    (rd_vld_o),
  .buf_any     (buf_any),
  .drain_act   (drain_act)
);

// File: tb/tb_eeprom_page_buf.sv
module tb_eeprom_page_buf;
  localparam int AW = 11;
  localparam int PW = 6;
  localparam int WC = 80;
  localparam int DEPTH = 1 << AW;
  localparam int PB = 1 << PW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          addr_load = 1'b0;
  logic [AW-1:0] addr_in = '0;
  logic          byte_vld = 1'b0;
  logic [7:0]    byte_in = '0;
  logic          commit = 1'b0;
  logic          rd_req = 1'b0;
  logic [AW-1:0] addr_out;
  logic          busy;
  logic          rd_vld;
  logic [7:0]    rd_data;

  always #5 clk = ~clk;

  eeprom_page_buf #(.ADDR_W(AW), .PAGE_W(PW), .WR_CYCLES(WC)) dut (
    .clk_i(clk), .rst_ni(rst_n), .addr_load_i(addr_load), .addr_i(addr_in),
    .byte_vld_i(byte_vld), .byte_i(byte_in), .commit_i(commit), .rd_req_i(rd_req),
    .addr_o(addr_out), .busy_o(busy), .rd_vld_o(rd_vld), .rd_data_o(rd_data)
  );

  int            n_chk = 0;
  int            n_err = 0;
  logic [7:0]    ref_mem [DEPTH];
  logic [AW-1:0] ref_addr;
  bit            pv [PB];
  logic [7:0]    pd [PB];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic bit pend_any();
    for (int i = 0; i < PB; i++) if (pv[i]) return 1'b1;
    return 1'b0;
  endfunction

  function automatic void pend_clear();
    for (int i = 0; i < PB; i++) pv[i] = 1'b0;
  endfunction

  // all tasks start and end at a falling edge
  task automatic do_load(input logic [AW-1:0] a);
    addr_load = 1'b1; addr_in = a;
    @(negedge clk);
    addr_load = 1'b0;
    ref_addr = a;
    pend_clear();
    chk(addr_out == a, "R3", addr_out, a);
  endtask

  task automatic do_byte(input logic [7:0] d);
    logic [PW-1:0] off;
    byte_vld = 1'b1; byte_in = d;
    @(negedge clk);
    byte_vld = 1'b0;
    off = ref_addr[PW-1:0];
    pd[off] = d; pv[off] = 1'b1;
    ref_addr[PW-1:0] = off + 1'b1;
  endtask

  task automatic do_read(input string req);
    logic [7:0] e;
    e = ref_mem[ref_addr];
    rd_req = 1'b1;
    @(negedge clk);
    rd_req = 1'b0;
    ref_addr = ref_addr + 1'b1;
    chk(rd_vld && rd_data == e, req, rd_data, e);
  endtask

  task automatic do_commit(input bit poke);
    int cnt;
    bit had;
    had = pend_any();
    commit = 1'b1;
    @(negedge clk);
    commit = 1'b0;
    if (had) begin
      for (int i = 0; i < PB; i++)
        if (pv[i]) ref_mem[{ref_addr[AW-1:PW], PW'(i)}] = pd[i];
      pend_clear();
      cnt = 0;
      while (busy && cnt < 4 * WC) begin
        cnt++;
        if (poke && cnt == 5) begin
          addr_load = 1'b1; addr_in = ~ref_addr; byte_vld = 1'b1; byte_in = 8'h5A;
          rd_req = 1'b1; commit = 1'b1;
          @(negedge clk);
          addr_load = 1'b0; byte_vld = 1'b0; rd_req = 1'b0; commit = 1'b0;
          chk(addr_out == ref_addr, "R8 addr", addr_out, ref_addr);
          chk(!rd_vld, "R8 rd_vld", rd_vld, 0);
        end else begin
          @(negedge clk);
        end
      end
      chk(cnt == WC, "R6 busy length", cnt, WC);
    end else begin
      chk(!busy, "R7 empty commit", busy, 0);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    logic [AW-1:0] a;
    int len;
    void'($urandom(32'h5EED_0042));
    for (int i = 0; i < DEPTH; i++) ref_mem[i] = 8'hFF;
    pend_clear();
    ref_addr = '0;

    repeat (3) @(negedge clk);
    chk(addr_out == 0 && !busy && !rd_vld, "R1 reset", {busy, rd_vld, addr_out}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(addr_out == 0 && !busy && !rd_vld, "R1 after release", {busy, rd_vld, addr_out}, 0);

    // erased contents
    do_load(11'h3F0);
    for (int i = 0; i < 4; i++) do_read("R2 erased");

    // page wrap: start at offset 60, 70 bytes
    do_load(11'h0BC);
    for (int i = 0; i < 70; i++) do_byte(8'(i + 1));
    chk(addr_out == 11'h082, "R4 offset wrap", addr_out, 11'h082);
    do_commit(1'b0);
    do_load(11'h080);
    for (int i = 0; i < PB; i++) do_read("R4 page data");

    // discard on reload, nothing written before commit
    do_load(11'h105);
    do_byte(8'h77); do_byte(8'h78);
    do_load(11'h105);
    do_read("R3 discarded bytes");
    do_commit(1'b0);

    // partial page merge, plus pokes during busy
    do_load(11'h104); do_byte(8'h11);
    do_load(11'h108); do_byte(8'h22);
    do_commit(1'b0);
    do_load(11'h105); do_byte(8'hAA); do_byte(8'hBB); do_byte(8'hCC);
    do_commit(1'b1);
    do_commit(1'b0);
    do_load(11'h100);
    for (int i = 0; i < 12; i++) do_read("R5 merge");

    // same-cycle priority
    do_load(11'h050);
    addr_load = 1'b1; addr_in = 11'h200; byte_vld = 1'b1; byte_in = 8'h99; rd_req = 1'b1;
    @(negedge clk);
    addr_load = 1'b0; byte_vld = 1'b0; rd_req = 1'b0;
    ref_addr = 11'h200;
    chk(addr_out == 11'h200, "R10 load wins", addr_out, 11'h200);
    chk(!rd_vld, "R10 read dropped", rd_vld, 0);
    do_commit(1'b0);
    do_byte(8'h31);
    byte_vld = 1'b1; byte_in = 8'h32; commit = 1'b1;
    @(negedge clk);
    byte_vld = 1'b0; commit = 1'b0;
    for (int i = 0; i < PB; i++)
      if (pv[i]) ref_mem[{ref_addr[AW-1:PW], PW'(i)}] = pd[i];
    pend_clear();
    while (busy) @(negedge clk);
    chk(addr_out == 11'h201, "R10 byte with commit dropped", addr_out, 11'h201);
    do_load(11'h200);
    do_read("R10 data"); do_read("R10 data");

    // full-array read wrap and page crossing
    do_load(11'h03E);
    for (int i = 0; i < 4; i++) do_read("R9 page cross");
    do_load(11'h7FE);
    for (int i = 0; i < 3; i++) do_read("R9 top wrap");
    chk(addr_out == 11'h001, "R9 wrapped addr", addr_out, 11'h001);

    // random bursts
    for (int it = 0; it < 25; it++) begin
      a = AW'($urandom);
      len = 1 + ($urandom % 80);
      do_load(a);
      for (int k = 0; k < len; k++) do_byte(8'($urandom));
      chk(addr_out == ref_addr, "R4 random addr", addr_out, ref_addr);
      do_commit(1'b0);
      do_load({a[AW-1:PW], PW'($urandom)});
      for (int k = 0; k < 6; k++) do_read("R5 random readback");
    end

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule